// File: doc/BRIEF.md
# Regulator Output Fault Supervisor

This block watches the output of a multiphase voltage regulator one digitized sample per clock and decides when to shut the power stage down. It takes a sense-voltage code, the programmed reference code and a signed offset correction, plus status flags for the main supply, the output-enable pin, a pre-overvoltage supply window and an in-progress reference transition. From these it drives two commands: `all_off`, which forces every power switch off, and `ls_on`, which forces the low-side switches on.

The undervoltage path compares the offset-corrected sense value against the reference. A fault needs two consecutive low samples to fire, and it then latches until the main supply or the enable pin is cycled. The pre-overvoltage path works on the raw sense code with hysteresis. It is enabled only while the supply sits in the window between the overvoltage-lockout level and the turn-on level. Both paths are frozen while the reference is moving and for a fixed tail of cycles after it settles. This keeps expected transients from tripping a fault.

Top module: `rail_fault_supervisor`

## Requirements
- R1: All voltage codes are 1 mV per LSB. `sense_mv` and `ref_mv` are unsigned 12-bit and `offset_mv` is signed 13-bit. A sample counts as low when `ref_mv - (sense_mv + offset_mv)` is strictly greater than 750. A difference of exactly 750 is not low.
- R2: `all_off` rises on the clock edge that registers the second of two consecutive low samples. A single low sample, or low samples separated by a non-low one, never raises it.
- R3: Once set, `all_off` stays high while `supply_ok` and `out_en` are both high, whatever the samples are. It clears on the edge that samples either flag low. It stays low after re-enable until a new fault is detected.
- R4: While `supply_ok` or `out_en` is low, no undervoltage detection takes place. The persistence count is held at zero.
- R5: While `vid_busy` is high, and on the 32 edges after it is first sampled low, the undervoltage count is held at zero and `ls_on` keeps its value. Detection resumes on the 33rd edge.
- R6: A new `vid_busy` pulse during the 32-edge tail restarts the full tail from its falling side.
- R7: While `preovp_window` is low, `ls_on` is low after the next edge.
- R8: With `preovp_window` high and no blanking, `ls_on` goes high one edge after `sense_mv` is strictly greater than 1800.
- R9: With `preovp_window` high and no blanking, `ls_on` holds its value while `sense_mv` is between 1450 and 1800 inclusive. It goes low one edge after `sense_mv` is below 1450.
- R10: `offset_mv` shifts only the undervoltage comparison. The pre-overvoltage comparison uses the raw `sense_mv`.
- R11: During and right after reset, `all_off` and `ls_on` are low and no blanking tail is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense_mv | input | 12 | Digitized sense voltage, 1 mV/LSB |
| ref_mv | input | 12 | Programmed reference code, 1 mV/LSB |
| offset_mv | input | 13 | Signed offset correction, 1 mV/LSB |
| supply_ok | input | 1 | Main supply above turn-on level |
| out_en | input | 1 | Output-enable pin level |
| preovp_window | input | 1 | Supply between overvoltage-lockout and turn-on levels |
| vid_busy | input | 1 | Reference transition in progress |
| all_off | output | 1 | Latched command: all power switches off |
| ls_on | output | 1 | Command: low-side switches on |

## Verification
Each output is a single register behind its comparators, so `ls_on` and the clearing of `all_off` are due one edge after the inputs that cause them. `all_off` is due one edge after the second consecutive low sample. The blanking tail moves that point out by exactly 33 edges from the falling side of `vid_busy`. The bench drives on the falling clock edge and samples on the next falling edge. Each table row therefore sees exactly one rising edge. The directed tests count edges explicitly and check on both sides of the point where an output is due to change, for example after 33 and after 34 edges.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Default geometry and thresholds, all codes at 1 mV per LSB
    localparam int SENSE_W_DEF    = 12;
    localparam int OFFSET_W_DEF   = 13;
    localparam int UV_MARGIN_DEF  = 750;
    localparam int UV_PERSIST_DEF = 2;
    localparam int BLANK_TAIL_DEF = 32;
    localparam int POVP_SET_DEF   = 1800;
    localparam int POVP_HYST_DEF  = 350;

    // Decision of the hysteretic pre-overvoltage comparator
    typedef enum logic [1:0] {
        POVP_KEEP    = 2'd0,
        POVP_ASSERT  = 2'd1,
        POVP_RELEASE = 2'd2
    } povp_act_e;

endpackage

// File: rtl/rfs_blank_timer.sv
module rfs_blank_timer #(
    parameter int TAIL = rfs_pkg::BLANK_TAIL_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vid_busy,
    output logic blank
);
    localparam int TW = $clog2(TAIL + 1);
    localparam logic [TW-1:0] TAIL_LOAD = TW'(TAIL);

    typedef struct packed {
        logic [TW-1:0] tail;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (vid_busy) begin
            // Any transition activity (re)loads the full tail
            tmr_d.tail = TAIL_LOAD;
        end else if (tmr_q.tail != '0) begin
            tmr_d.tail = tmr_q.tail - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign blank = vid_busy || (tmr_q.tail != '0);

endmodule

// File: rtl/rfs_uv_compare.sv
module rfs_uv_compare #(
    parameter int SW     = rfs_pkg::SENSE_W_DEF,
    parameter int OW     = rfs_pkg::OFFSET_W_DEF,
    parameter int MARGIN = rfs_pkg::UV_MARGIN_DEF
) (
    input  logic [SW-1:0]        sense,
    input  logic [SW-1:0]        refv,
    input  logic signed [OW-1:0] offset,
    output logic                 below
);
    // Wide enough for sum and difference of all operands without wrap
    localparam int EW = ((SW > OW) ? SW : OW) + 3;
    localparam logic signed [EW-1:0] MARGIN_S = EW'(MARGIN);

    logic signed [EW-1:0] sense_s;
    logic signed [EW-1:0] ref_s;
    logic signed [EW-1:0] off_s;
    logic signed [EW-1:0] eff_s;
    logic signed [EW-1:0] deficit;

    always_comb begin
        sense_s = EW'($signed({1'b0, sense}));
        ref_s   = EW'($signed({1'b0, refv}));
        off_s   = EW'(offset);
        // Output-referred value: sense plus the offset drop
        eff_s   = sense_s + off_s;
        deficit = ref_s - eff_s;
        below   = deficit > MARGIN_S;
    end

endmodule

// File: rtl/rfs_preovp_cmp.sv
module rfs_preovp_cmp
    import rfs_pkg::*;
#(
    parameter int SW   = rfs_pkg::SENSE_W_DEF,
    parameter int SET  = rfs_pkg::POVP_SET_DEF,
    parameter int HYST = rfs_pkg::POVP_HYST_DEF
) (
    input  logic [SW-1:0] sense,
    output povp_act_e     act
);
    localparam logic [SW-1:0] SET_CODE = SW'(SET);
    localparam logic [SW-1:0] REL_CODE = SW'(SET - HYST);

    always_comb begin
        if (sense > SET_CODE) begin
            act = POVP_ASSERT;
        end else if (sense < REL_CODE) begin
            act = POVP_RELEASE;
        end else begin
            act = POVP_KEEP;
        end
    end

endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor
    import rfs_pkg::*;
#(
    parameter int SENSE_W    = SENSE_W_DEF,
    parameter int OFFSET_W   = OFFSET_W_DEF,
    parameter int UV_MARGIN  = UV_MARGIN_DEF,
    parameter int UV_PERSIST = UV_PERSIST_DEF,
    parameter int BLANK_TAIL = BLANK_TAIL_DEF,
    parameter int POVP_SET   = POVP_SET_DEF,
    parameter int POVP_HYST  = POVP_HYST_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SENSE_W-1:0]         sense_mv,
    input  logic [SENSE_W-1:0]         ref_mv,
    input  logic signed [OFFSET_W-1:0] offset_mv,
    input  logic                       supply_ok,
    input  logic                       out_en,
    input  logic                       preovp_window,
    input  logic                       vid_busy,
    output logic                       all_off,
    output logic                       ls_on
);
    localparam int CW = $clog2(UV_PERSIST + 1);
    localparam logic [CW-1:0] PERSIST_LAST = CW'(UV_PERSIST - 1);
    localparam logic [CW-1:0] PERSIST_MAX  = CW'(UV_PERSIST);

    typedef struct packed {
        logic [CW-1:0] uv_cnt;
        logic          fault;
        logic          ls;
    } sup_t;

    sup_t      st_d, st_q;
    logic      blank;
    logic      uv_below;
    logic      checks_on;
    povp_act_e povp_act;

    rfs_blank_timer #(
        .TAIL (BLANK_TAIL)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_busy (vid_busy),
        .blank    (blank)
    );

    rfs_uv_compare #(
        .SW     (SENSE_W),
        .OW     (OFFSET_W),
        .MARGIN (UV_MARGIN)
    ) u_uv (
        .sense  (sense_mv),
        .refv   (ref_mv),
        .offset (offset_mv),
        .below  (uv_below)
    );

    rfs_preovp_cmp #(
        .SW   (SENSE_W),
        .SET  (POVP_SET),
        .HYST (POVP_HYST)
    ) u_povp (
        .sense (sense_mv),
        .act   (povp_act)
    );

    always_comb begin
        st_d      = st_q;
        checks_on = supply_ok && out_en;

        // Undervoltage path: persistence count and latched fault
        if (!checks_on) begin
            st_d.uv_cnt = '0;
            st_d.fault  = 1'b0;
        end else if (blank) begin
            st_d.uv_cnt = '0;
        end else if (uv_below) begin
            if (st_q.uv_cnt >= PERSIST_LAST) begin
                st_d.fault = 1'b1;
            end
            if (st_q.uv_cnt < PERSIST_MAX) begin
                st_d.uv_cnt = st_q.uv_cnt + 1'b1;
            end
        end else begin
            st_d.uv_cnt = '0;
        end

        // Pre-overvoltage path: hysteretic, only inside its supply window
        if (!preovp_window) begin
            st_d.ls = 1'b0;
        end else if (!blank) begin
            case (povp_act)
                POVP_ASSERT:  st_d.ls = 1'b1;
                POVP_RELEASE: st_d.ls = 1'b0;
                default:      st_d.ls = st_q.ls;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign all_off = st_q.fault;
    assign ls_on   = st_q.ls;

endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int SENSE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SENSE_W-1:0] sense_mv,
    input logic               supply_ok,
    input logic               out_en,
    input logic               preovp_window,
    input logic               blank,
    input logic               uv_below,
    input logic               all_off,
    input logic               ls_on
);
    localparam logic [SENSE_W-1:0] SET_CODE = SENSE_W'(1800);
    localparam logic [SENSE_W-1:0] REL_CODE = SENSE_W'(1450);

    assert_two_low_samples_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_off) |-> ($past(uv_below) && $past(uv_below, 2) && !$past(blank)));

    assert_fault_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && supply_ok && out_en) |=> all_off);

    assert_fault_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok || !out_en) |=> !all_off);

    assert_blank_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && supply_ok && out_en) |=> $stable(all_off));

    assert_ls_blank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && preovp_window) |=> $stable(ls_on));

    assert_ls_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !preovp_window |=> !ls_on);

    assert_ls_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (preovp_window && !blank && (sense_mv > SET_CODE)) |=> ls_on);

    assert_ls_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (preovp_window && !blank && (sense_mv < REL_CODE)) |=> !ls_on);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R11: assert (!all_off && !ls_on);
        end
    end

endmodule

bind rail_fault_supervisor rfs_checker #(
    .SENSE_W (SENSE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sense_mv      (sense_mv),
    .supply_ok     (supply_ok),
    .out_en        (out_en),
    .preovp_window (preovp_window),
    .blank         (blank),
    .uv_below      (uv_below),
    .all_off       (all_off),
    .ls_on         (ls_on)
);

// File: tb/sim_rail_fault_supervisor.sv
`timescale 1ns/1ps
module sim_rail_fault_supervisor;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [11:0]        sense_mv = 12'd1000;
    logic [11:0]        ref_mv = 12'd1000;
    logic signed [12:0] offset_mv = '0;
    logic               supply_ok = 1'b1;
    logic               out_en = 1'b1;
    logic               preovp_window = 1'b0;
    logic               vid_busy = 1'b0;
    logic               all_off;
    logic               ls_on;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    rail_fault_supervisor u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .sense_mv      (sense_mv),
        .ref_mv        (ref_mv),
        .offset_mv     (offset_mv),
        .supply_ok     (supply_ok),
        .out_en        (out_en),
        .preovp_window (preovp_window),
        .vid_busy      (vid_busy),
        .all_off       (all_off),
        .ls_on         (ls_on)
    );

    typedef struct packed {
        logic [11:0]        sense;
        logic [11:0]        refc;
        logic signed [12:0] off;
        logic               sup;
        logic               en;
        logic               win;
        logic               exp_off;
        logic               exp_ls;
    } vec_t;

    // One row per rising edge; expected values are after that edge
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{12'd1000, 12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // idle
        '{12'd249,  12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 first low
        '{12'd250,  12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 exactly 750
        '{12'd249,  12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 restart
        '{12'd249,  12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 trip
        '{12'd1000, 12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 latched
        '{12'd1000, 12'd1000, 13'sd0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 enable low
        '{12'd1000, 12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 re-enable
        '{12'd300,  12'd1000, -13'sd60, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 offset low
        '{12'd300,  12'd1000, -13'sd60, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R1 offset trip
        '{12'd1000, 12'd1000, 13'sd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 supply low
        '{12'd200,  12'd1000, 13'sd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 no detect
        '{12'd200,  12'd1000, 13'sd100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 offset lifts
        '{12'd200,  12'd1000, 13'sd100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 still fine
        '{12'd1800, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 not strict
        '{12'd1801, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 set
        '{12'd1450, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R9 hold
        '{12'd1449, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 release
        '{12'd2000, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 set again
        '{12'd2000, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 window off
        '{12'd2000, 12'd0,    13'sd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1}, // R8 window on
        '{12'd1440, 12'd0,    13'sd900, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 raw sense
        '{12'd1000, 12'd1000, 13'sd0,   1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // back to idle
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_total++;
        if (act === exp) begin
            n_pass++;
        end else begin
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: quiet in and out of reset
        repeat (3) @(negedge clk);
        check("R11 all_off in reset", all_off, 1'b0);
        check("R11 ls_on in reset", ls_on, 1'b0);
        rst_n = 1'b1;
        edges(1);
        check("R11 all_off after reset", all_off, 1'b0);

        for (int i = 0; i < NV; i++) begin
            sense_mv      = VECS[i].sense;
            ref_mv        = VECS[i].refc;
            offset_mv     = VECS[i].off;
            supply_ok     = VECS[i].sup;
            out_en        = VECS[i].en;
            preovp_window = VECS[i].win;
            edges(1);
            check($sformatf("R1-table row %0d all_off", i), all_off, VECS[i].exp_off);
            check($sformatf("R8-table row %0d ls_on", i), ls_on, VECS[i].exp_ls);
        end

        // R11: no tail pending after reset -> detection on the first edges
        sense_mv = 12'd200; ref_mv = 12'd1000;
        edges(2);
        check("R11 detect right away", all_off, 1'b1);
        out_en = 1'b0; edges(1); out_en = 1'b1;

        // R5: blanking during busy and 32 tail edges
        vid_busy = 1'b1;
        edges(3);
        check("R5 busy blanks", all_off, 1'b0);
        vid_busy = 1'b0;
        edges(33);
        check("R5 tail 33 edges", all_off, 1'b0);
        edges(1);
        check("R5 detect resumes", all_off, 1'b1);

        // R6: restart of tail
        out_en = 1'b0; edges(1); out_en = 1'b1;
        vid_busy = 1'b1; edges(1); vid_busy = 1'b0;
        edges(20);
        vid_busy = 1'b1; edges(1); vid_busy = 1'b0;
        edges(32);
        check("R6 tail restarted", all_off, 1'b0);
        edges(2);
        check("R6 detect after restart", all_off, 1'b1);

        // R5: ls_on frozen during blanking
        supply_ok = 1'b0; preovp_window = 1'b1; sense_mv = 12'd2000;
        edges(1);
        check("R5 ls set before blank", ls_on, 1'b1);
        vid_busy = 1'b1; sense_mv = 12'd1000;
        edges(3);
        check("R5 ls held while busy", ls_on, 1'b1);
        vid_busy = 1'b0;
        edges(32);
        check("R5 ls held in tail", ls_on, 1'b1);
        edges(1);
        check("R5 ls released after tail", ls_on, 1'b0);

        // R11: reset clears a latched fault
        supply_ok = 1'b1; preovp_window = 1'b0; sense_mv = 12'd200;
        edges(2);
        check("R11 fault before reset", all_off, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R11 reset clears fault", all_off, 1'b0);
        edges(1);
        rst_n = 1'b1;
        sense_mv = 12'd1000;
        edges(1);
        check("R11 quiet after reset", all_off, 1'b0);

        finish_run();
    end

endmodule